// File: doc/BRIEF.md
# Full-Duplex SPI Byte Port with Master and Slave Modes

This block is a byte-wide serial peripheral port that moves one byte out and one byte in at the same time, MSB first. One control bit picks master or slave operation. In master mode the port makes the serial clock from the core clock through a programmable divider and starts a byte whenever software has loaded the transmit holding register. In slave mode it follows an external serial clock and a low-active select. It keeps sending and taking bytes for as long as the select stays low. Clock polarity and phase can be set for both modes.

Software sees five registers on a small strobe bus. The bus has no back-pressure: a write or read strobe is taken in the cycle it is high, and read data is combinational on the address. The data path follows a valid-flag discipline instead of a ready signal. A transmit-valid flag tells the serializer that a fresh byte is waiting. A receive-valid flag tells software that a byte is waiting. When a completed byte arrives while the receive holding register is still full, one of two loss rules applies, and a sticky overflow flag records the loss.

In slave mode the port samples the external clock, select and data input through two-flop synchronisers and finds clock edges in the core clock domain. Each pin has a separate input, output and output-enable, so the pad ring can make the pins bidirectional.

Top module: `spi_byte_port`

## Requirements
- R1: Each transfer is 8 bits, most significant bit first, and a byte ends after 8 serial clock periods (16 edges).
- R2: In master mode `sclk_oe` and `mosi_oe` are 1 and `miso_oe` is 0. In slave mode `sclk_oe` and `mosi_oe` are 0, and `miso_oe` is 1 only while the synchronised select is low.
- R3: In master mode a byte starts when the port is idle and transmit-valid is set. Every serial clock half period lasts DIV+1 core clocks, and between bytes the serial clock rests at the CPOL level.
- R4: The leading edge is the first edge that moves away from the CPOL level. With CPHA=0, data is sampled on leading edges and changed on trailing edges. With CPHA=1, data is changed on leading edges and sampled on trailing edges.
- R5: The register addresses are: 0 control, 1 divider DIV, 2 transmit data, 3 receive data, 4 status. Control bit 0 selects master, bit 1 is CPOL, bit 2 is CPHA and bit 3 is keep-old. Status bit 0 is transmit-valid, bit 3 is receive-valid and bit 5 is overflow. All other status bits read 0.
- R6: Writing the transmit register sets transmit-valid. Loading the byte into the shifter clears transmit-valid.
- R7: A completed byte sets receive-valid. Reading the receive register clears receive-valid.
- R8: If a byte completes while receive-valid is already set, overflow is set. With keep-old=0 the new byte overwrites the held byte. With keep-old=1 the new byte is discarded. Overflow stays set until the status register is read.
- R9: In slave mode a falling select starts a frame, and bytes follow back to back until select rises. A rise in the middle of a byte discards the partial byte, and the next frame starts aligned at its first bit.
- R10: In slave mode, if transmit-valid is clear when a byte starts, the last loaded byte is sent again.
- R11: In slave mode the port receives correctly with an external serial clock at one quarter of the core clock.
- R12: After reset every register and flag is 0 (slave mode, CPOL=0, DIV=0), all output enables are 0 and `sclk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; drives read side effects |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| sclk_i | input | 1 | Serial clock from an external master |
| sclk_o | output | 1 | Serial clock generated in master mode |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Output enable for the master-out pin |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Output enable for the slave-out pin |
| cs_n_i | input | 1 | Slave select, active low |

## Verification
The two situations hardest to reach from the ports both involve back-to-back slave bytes inside one frame. These are the second byte that must resend the last transmit value, and the receive holding register being hit while still full. The stimulus keeps select low across two bytes, does not write the transmit register between them and skips the receive read. This runs once with keep-old clear and once with it set, so that both overflow outcomes appear. A frame cut off after four bits, followed by a clean frame, shows that alignment is restored. The quarter-rate slave runs confirm that the synchroniser delay leaves enough margin.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int unsigned REG_AW = 3;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t A_CTRL = 3'd0;
  localparam reg_addr_t A_DIV  = 3'd1;
  localparam reg_addr_t A_TX   = 3'd2;
  localparam reg_addr_t A_RX   = 3'd3;
  localparam reg_addr_t A_STAT = 3'd4;

  localparam int unsigned CB_MASTER = 0;
  localparam int unsigned CB_CPOL   = 1;
  localparam int unsigned CB_CPHA   = 2;
  localparam int unsigned CB_KEEP   = 3;

  localparam int unsigned SB_TXV = 0;
  localparam int unsigned SB_RXV = 3;
  localparam int unsigned SB_OVF = 5;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= RST_VAL;
        else        stage[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RST_VAL;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= cpol;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_engine.sv
module spi_engine #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  logic              start,
  input  logic              abort,
  input  logic              cont,
  input  logic              edge_ev,
  input  logic              sdi,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sdo,
  output logic              take,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              active
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned CNT_W = $clog2(EDGES);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);

  logic [CNT_W-1:0]  eidx;
  logic [DATA_W-1:0] tx_sh, rx_sh, last_tx, rx_next;
  logic lead, at_last, ev, sample, shift, load;

  assign ev      = edge_ev && active;
  assign lead    = ~eidx[0];
  assign at_last = (eidx == LAST_EDGE);
  assign sample  = ev && (cpha ? !lead : lead);
  assign shift   = ev && !at_last && (cpha ? (lead && eidx != '0) : !lead);
  assign load    = start || (ev && at_last && cont && !abort);
  assign take    = load && tx_valid;
  assign done    = ev && at_last;
  assign rx_next = {rx_sh[DATA_W-2:0], sdi};
  assign rx_data = cpha ? rx_next : rx_sh;
  assign sdo     = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      eidx   <= '0;
    end else if (abort) begin
      active <= 1'b0;
      eidx   <= '0;
    end else if (start) begin
      active <= 1'b1;
      eidx   <= '0;
    end else if (ev) begin
      if (at_last) begin
        eidx   <= '0;
        active <= cont;
      end else begin
        eidx   <= eidx + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      last_tx <= '0;
    end else if (load) begin
      tx_sh   <= tx_valid ? tx_data : last_tx;
      last_tx <= tx_valid ? tx_data : last_tx;
    end else if (shift) begin
      tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_sh <= '0;
    else if (sample) rx_sh <= rx_next;
  end
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              cs_n_i
);
  // control and data registers
  logic              mode_master, mode_cpol, mode_cpha, mode_keep;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_hold, rx_hold;
  logic              tx_valid, rx_valid, ovf;

  // synchronised pins and edge history
  logic sclk_s, csn_s, mosi_s, sclk_d, csn_d;

  // engine and clock generator wiring
  logic              eng_start, eng_abort, eng_edge, eng_sdi, eng_sdo;
  logic              eng_take, eng_done, eng_active;
  logic [DATA_W-1:0] eng_rx;
  logic              gen_sclk, gen_tick;

  logic wr_ctrl, wr_div, wr_tx, rd_rx, rd_stat;
  logic slave_fall, slave_edge, master_go, rx_clash;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_div  = bus_wr && (bus_addr == A_DIV);
  assign wr_tx   = bus_wr && (bus_addr == A_TX);
  assign rd_rx   = bus_rd && (bus_addr == A_RX);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);

  spi_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sclk_i, cs_n_i, mosi_i}),
    .dout ({sclk_s, csn_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign slave_fall = !mode_master && csn_d && !csn_s;
  assign slave_edge = !mode_master && !csn_s && (sclk_s != sclk_d);
  assign master_go  = mode_master && !eng_active && tx_valid;

  assign eng_start = master_go || slave_fall;
  assign eng_abort = !mode_master && csn_s;
  assign eng_edge  = mode_master ? gen_tick : slave_edge;
  assign eng_sdi   = mode_master ? miso_i : mosi_s;

  spi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (mode_master && eng_active),
    .cpol (mode_cpol),
    .div  (div_q),
    .sclk (gen_sclk),
    .tick (gen_tick)
  );

  spi_engine #(.DATA_W(DATA_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpha    (mode_cpha),
    .start   (eng_start),
    .abort   (eng_abort),
    .cont    (!mode_master),
    .edge_ev (eng_edge),
    .sdi     (eng_sdi),
    .tx_valid(tx_valid),
    .tx_data (tx_hold),
    .sdo     (eng_sdo),
    .take    (eng_take),
    .done    (eng_done),
    .rx_data (eng_rx),
    .active  (eng_active)
  );

  // control register and divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_master <= 1'b0;
      mode_cpol   <= 1'b0;
      mode_cpha   <= 1'b0;
      mode_keep   <= 1'b0;
      div_q       <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_master <= bus_wdata[CB_MASTER];
        mode_cpol   <= bus_wdata[CB_CPOL];
        mode_cpha   <= bus_wdata[CB_CPHA];
        mode_keep   <= bus_wdata[CB_KEEP];
      end
      if (wr_div) div_q <= DIV_W'(bus_wdata);
    end
  end

  // transmit holding register: a write wins over a coincident load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold  <= '0;
      tx_valid <= 1'b0;
    end else if (wr_tx) begin
      tx_hold  <= bus_wdata;
      tx_valid <= 1'b1;
    end else if (eng_take) begin
      tx_valid <= 1'b0;
    end
  end

  // receive holding register; a read in the completion cycle frees the slot
  assign rx_clash = eng_done && rx_valid && !rd_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold  <= '0;
      rx_valid <= 1'b0;
    end else if (eng_done) begin
      rx_valid <= 1'b1;
      if (!(rx_clash && mode_keep)) rx_hold <= eng_rx;
    end else if (rd_rx) begin
      rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf <= 1'b0;
    else if (rx_clash) ovf <= 1'b1;
    else if (rd_stat)  ovf <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[CB_MASTER] = mode_master;
        bus_rdata[CB_CPOL]   = mode_cpol;
        bus_rdata[CB_CPHA]   = mode_cpha;
        bus_rdata[CB_KEEP]   = mode_keep;
      end
      A_DIV:  bus_rdata = DATA_W'(div_q);
      A_TX:   bus_rdata = tx_hold;
      A_RX:   bus_rdata = rx_hold;
      A_STAT: begin
        bus_rdata[SB_TXV] = tx_valid;
        bus_rdata[SB_RXV] = rx_valid;
        bus_rdata[SB_OVF] = ovf;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign sclk_o  = gen_sclk;
  assign sclk_oe = mode_master;
  assign mosi_o  = eng_sdo;
  assign mosi_oe = mode_master;
  assign miso_o  = eng_sdo;
  assign miso_oe = !mode_master && !csn_s;
endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk
  import spi_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_master,
  input logic              mode_cpol,
  input logic [DIV_W-1:0]  div_q,
  input logic              sclk_o,
  input logic              eng_active,
  input logic              eng_done,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [REG_AW-1:0] bus_addr,
  input logic              tx_valid,
  input logic              rx_valid,
  input logic              ovf
);
  logic             sclk_q, act_q, cpol_q;
  logic [DIV_W:0]   hcnt;
  logic             tog;

  assign tog = (sclk_o != sclk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      act_q  <= 1'b0;
      cpol_q <= 1'b0;
      hcnt   <= '0;
    end else begin
      sclk_q <= sclk_o;
      act_q  <= eng_active;
      cpol_q <= mode_cpol;
      if (!eng_active) hcnt <= '0;
      else if (tog)    hcnt <= {{DIV_W{1'b0}}, 1'b1};
      else             hcnt <= hcnt + {{DIV_W{1'b0}}, 1'b1};
    end
  end

  // R3: each master half period spans DIV+1 core clocks
  p_half_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && act_q && tog) |-> (hcnt == ({1'b0, div_q} + {{DIV_W{1'b0}}, 1'b1})));

  // R3: idle master clock sits at CPOL
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && !eng_active && !act_q && (mode_cpol == cpol_q)) |-> (sclk_o == mode_cpol));

  // R6: a transmit write leaves transmit-valid set
  p_txv_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TX) |=> tx_valid);

  // R7: completion sets receive-valid
  p_rxv_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> rx_valid);

  // R7: a receive read with no completion clears receive-valid
  p_rxv_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RX && !eng_done) |=> !rx_valid);

  // R8: overflow is sticky until a status read
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(bus_rd && bus_addr == A_STAT)) |=> ovf);
endmodule

bind spi_byte_port spi_byte_port_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_master(mode_master),
  .mode_cpol  (mode_cpol),
  .div_q      (div_q),
  .sclk_o     (sclk_o),
  .eng_active (eng_active),
  .eng_done   (eng_done),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .tx_valid   (tx_valid),
  .rx_valid   (rx_valid),
  .ovf        (ovf)
);

// File: tb/spi_byte_port_tb.sv
module spi_byte_port_tb;
  localparam int CLK_NS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       sclk_i = 1'b0, mosi_i = 1'b0, cs_n_i = 1'b1;
  logic       sclk_o, sclk_oe, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign miso_i = mosi_o;  // master loopback

  spi_byte_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .cs_n_i(cs_n_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // master byte with loopback; bench captures MOSI on sample edges
  task automatic m_xfer(input logic [7:0] d, input int dv, input bit pol, input bit pha);
    logic [7:0] cap, rd;
    longint t_prev, t_now;
    bit ok_int;
    bus_write(3'd0, {5'b0, pha, pol, 1'b1});
    bus_write(3'd1, dv[7:0]);
    repeat (2) @(negedge clk);
    chk("R2 master enables", {29'b0, sclk_oe, mosi_oe, miso_oe}, 32'b110);
    bus_write(3'd2, d);
    cap = '0; ok_int = 1'b1; t_prev = 0;
    for (int e = 0; e < 16; e++) begin
      @(sclk_o);
      t_now = $time;
      if (e > 0 && (t_now - t_prev) != longint'((dv + 1) * CLK_NS)) ok_int = 1'b0;
      t_prev = t_now;
      if (((e % 2) == 1) == pha) cap = {cap[6:0], mosi_o};  // R4 sample edges
    end
    repeat (3) @(negedge clk);
    chk("R3 half period", {31'b0, ok_int}, 32'd1);
    chk("R3 idle level", {31'b0, sclk_o}, {31'b0, pol});
    chk("R1 R4 MSB-first capture", {24'b0, cap}, {24'b0, d});
    bus_read(3'd4, rd);
    chk("R6 R7 status after byte", {24'b0, rd}, 32'h08);
    bus_read(3'd3, rd);
    chk("R1 loopback receive", {24'b0, rd}, {24'b0, d});
  endtask

  // bench acting as master towards a slave-mode DUT
  task automatic s_bits(input logic [7:0] mo, input int nb, input int h,
                        input bit pol, input bit pha, output logic [7:0] mi);
    mi = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      if (!pha) begin
        mosi_i = mo[i];
        repeat (h) @(negedge clk);
        sclk_i = ~pol; mi[i] = miso_o;
        repeat (h) @(negedge clk);
        sclk_i = pol;
      end else begin
        sclk_i = ~pol; mosi_i = mo[i];
        repeat (h) @(negedge clk);
        sclk_i = pol; mi[i] = miso_o;
        repeat (h) @(negedge clk);
      end
    end
  endtask

  task automatic cs_begin(input int h, input bit pol);
    sclk_i = pol;
    repeat (4) @(negedge clk);
    cs_n_i = 1'b0;
    repeat (h) @(negedge clk);
  endtask

  task automatic cs_end(input int h);
    repeat (h) @(negedge clk);
    cs_n_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rd, mi, mi2, txb, mob;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    bus_read(3'd4, rd); chk("R12 status reset", {24'b0, rd}, 32'h00);
    bus_read(3'd0, rd); chk("R12 ctrl reset", {24'b0, rd}, 32'h00);
    bus_read(3'd1, rd); chk("R12 div reset", {24'b0, rd}, 32'h00);
    chk("R12 pins reset", {28'b0, sclk_o, sclk_oe, mosi_oe, miso_oe}, 32'h0);

    // R5 register readback
    bus_write(3'd0, 8'h0E);
    bus_write(3'd1, 8'h9C);
    bus_read(3'd0, rd); chk("R5 ctrl readback", {24'b0, rd}, 32'h0E);
    bus_read(3'd1, rd); chk("R5 div readback", {24'b0, rd}, 32'h9C);
    bus_write(3'd0, 8'h00);

    // master: exhaustive data sweep in mode 0, fastest divider
    for (int v = 0; v < 256; v++) m_xfer(v[7:0], 0, 1'b0, 1'b0);
    // master: all clock modes across several dividers
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 4; k++) begin
        m_xfer(8'hA5 ^ 8'(m * 37 + k), (k == 3) ? 9 : k, m[0], m[1]);
        m_xfer(8'h3C + 8'(k), (k == 3) ? 9 : k, m[0], m[1]);
      end

    // slave: every mode, half period of 4 core clocks
    for (int m = 0; m < 4; m++) begin
      bus_write(3'd0, {5'b0, m[1], m[0], 1'b0});
      txb = 8'hC3 ^ 8'(m * 17);
      mob = 8'h5A + 8'(m);
      bus_write(3'd2, txb);
      cs_begin(4, m[0]);
      chk("R2 slave enables", {29'b0, sclk_oe, mosi_oe, miso_oe}, 32'b001);
      s_bits(mob, 8, 4, m[0], m[1], mi);
      cs_end(4);
      chk("R2 miso released", {31'b0, miso_oe}, 32'd0);
      chk("R1 R4 slave sends", {24'b0, mi}, {24'b0, txb});
      bus_read(3'd4, rd); chk("R6 R7 slave status", {24'b0, rd}, 32'h08);
      bus_read(3'd3, rd); chk("R9 slave receive", {24'b0, rd}, {24'b0, mob});
    end

    // R10 and R8: two bytes in one frame, one TX write, no RX read, overwrite
    bus_write(3'd0, 8'h00);
    bus_write(3'd2, 8'h81);
    cs_begin(4, 1'b0);
    s_bits(8'h11, 8, 4, 1'b0, 1'b0, mi);
    s_bits(8'h22, 8, 4, 1'b0, 1'b0, mi2);
    cs_end(4);
    chk("R10 first byte", {24'b0, mi}, 32'h81);
    chk("R10 repeated byte", {24'b0, mi2}, 32'h81);
    bus_read(3'd4, rd); chk("R8 overflow set", {24'b0, rd}, 32'h28);
    bus_read(3'd4, rd); chk("R8 overflow cleared by status read", {24'b0, rd}, 32'h08);
    bus_read(3'd3, rd); chk("R8 overwrite keeps newest", {24'b0, rd}, 32'h22);
    bus_read(3'd4, rd); chk("R7 rx read clears valid", {24'b0, rd}, 32'h00);

    // R8 keep-old: new byte discarded
    bus_write(3'd0, 8'h0C);
    bus_write(3'd2, 8'h7E);
    cs_begin(4, 1'b0);
    s_bits(8'h33, 8, 4, 1'b0, 1'b1, mi);
    s_bits(8'h44, 8, 4, 1'b0, 1'b1, mi2);
    cs_end(4);
    chk("R10 repeat in cpha1", {24'b0, mi2}, 32'h7E);
    bus_read(3'd4, rd); chk("R8 overflow keep-old", {24'b0, rd}, 32'h28);
    bus_read(3'd3, rd); chk("R8 keep-old holds first", {24'b0, rd}, 32'h33);

    // R11 quarter-rate receive in every mode
    for (int m = 0; m < 4; m++) begin
      bus_write(3'd0, {5'b0, m[1], m[0], 1'b0});
      mob = 8'hB4 ^ 8'(m * 29);
      cs_begin(2, m[0]);
      s_bits(mob, 8, 2, m[0], m[1], mi);
      cs_end(2);
      bus_read(3'd3, rd); chk("R11 quarter rate receive", {24'b0, rd}, {24'b0, mob});
    end

    // R9 abort mid-byte, then a clean frame
    bus_write(3'd0, 8'h00);
    bus_read(3'd4, rd);
    cs_begin(4, 1'b0);
    s_bits(8'hF0, 4, 4, 1'b0, 1'b0, mi);
    cs_end(4);
    bus_read(3'd4, rd); chk("R9 partial byte discarded", {24'b0, rd}, 32'h00);
    cs_begin(4, 1'b0);
    s_bits(8'hE7, 8, 4, 1'b0, 1'b0, mi);
    cs_end(4);
    bus_read(3'd3, rd); chk("R9 realigned after abort", {24'b0, rd}, 32'hE7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule